// File: doc/BRIEF.md
# Multicycle Instruction Sequencer for a Load/Store Core

This block is the control unit of a 32-bit load/store processor that runs each instruction over several clock cycles on one shared ALU and one shared memory port. Every instruction starts with the same two cycles. The first fetches the instruction word and advances the program counter. The second reads the two source registers and computes a possible branch target. After that, the 6-bit opcode picks one of four paths: register-to-register arithmetic, word load, word store, or branch-if-equal. Any other opcode goes straight back to fetch. Branches finish in 3 cycles, arithmetic and stores in 4, and loads in 5.

In each cycle the block drives the datapath enables and selects: program counter write and its source, instruction register write, operand latch, ALU result latch, memory read and write with the address source, register-file write with its destination and data source, ALU input selects, and a 3-bit ALU operation. The datapath feeds back only the opcode, the function field and the result of an A-equals-B comparison. An end-of-instruction strobe marks the final cycle of each instruction. A parameter chooses whether the state is held one-hot or as a binary index. The behaviour is the same either way.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in the fetch cycle, and the first cycle after reset shows the fetch controls.
- R2: Fetch cycle: memRead=1 with addrFromAluOut=0, irWrite=1, and pcWrite=1 with pcFromAluOut=0. The ALU adds PC (aluAFromReg=0) and the constant 4 (aluBSel encoding: 0=B, 1=constant 4, 2=sign-extended imm, 3=sign-extended imm shifted left 2), so PC becomes PC+4.
- R3: The decode cycle drives the same datapath controls for every opcode: loadRegAB=1, loadAluOut=1, aluAFromReg=0, aluBSel=3, aluOp=ADD, and every write enable and memRead low. The datapath reads rs (bits 25:21) and rt (bits 20:16) from an instruction whose opcode is bits 31:26, rd bits 15:11, function bits 5:0 and immediate bits 15:0.
- R4: Branch-if-equal (opcode 000100) takes 3 cycles. In cycle 3 the ALU subtracts B from A. PC is loaded with the latched target only when A equals B, so a taken branch ends with PC = PC+4 + (imm<<2).
- R5: R-type (opcode 000000) takes 4 cycles and writes rs op rt into rd. The function field sets aluOp in cycle 3: 0x20 gives ADD=010, 0x22 gives SUB=110, 0x24 gives AND=000, 0x25 gives OR=001, 0x2A gives signed set-less-than=111, and any other value gives ADD.
- R6: Load word (opcode 100011) takes 5 cycles and writes the memory word at rs+sext(imm) into rt.
- R7: Store word (opcode 101011) takes 4 cycles and writes rt to memory at rs+sext(imm).
- R8: Any other opcode ends after 2 cycles. It writes no register and no memory, and its only PC write is the fetch increment.
- R9: Writes happen only where they belong: regWrite only in an instruction's final cycle, memWrite only in a store's fourth cycle, pcWrite only in fetch or a taken branch, and memRead and memWrite never together.
- R10: instrDone is high in exactly the last cycle of each instruction, and the next cycle is a fetch.
- R11: A state register built with ONE_HOT=1 and one built with ONE_HOT=0 drive identical outputs every cycle for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Opcode field of the instruction register |
| funct | input | FN_W | Function field of the instruction register |
| aEqB | input | 1 | Operand latches A and B are equal |
| pcWrite | output | 1 | Load PC |
| pcFromAluOut | output | 1 | PC source: 1 = latched ALU result, 0 = live ALU result |
| irWrite | output | 1 | Load instruction register from memory |
| memRead | output | 1 | Memory read |
| memWrite | output | 1 | Memory write of B |
| addrFromAluOut | output | 1 | Memory address: 1 = latched ALU result, 0 = PC |
| loadRegAB | output | 1 | Latch register-file reads into A and B |
| loadAluOut | output | 1 | Latch ALU result |
| regWrite | output | 1 | Register-file write |
| dstIsRd | output | 1 | Write destination: 1 = rd, 0 = rt |
| wbFromMdr | output | 1 | Write data: 1 = memory data register, 0 = latched ALU result |
| aluAFromReg | output | 1 | ALU input A: 1 = A latch, 0 = PC |
| aluBSel | output | 2 | ALU input B select (see R2) |
| aluOp | output | 3 | ALU operation (see R5) |
| instrDone | output | 1 | Final cycle of the current instruction |

## Verification
The bench builds two copies with the default widths and opcode values, one with ONE_HOT=1 and one with ONE_HOT=0, and runs them in lockstep on the same inputs. The first copy drives a behavioural datapath, and the second is compared against it output by output. Running both copies reaches the binary-index decode path that a single default build would leave untouched. Because the opcode widths and values are the defaults, every opcode outside the four classes, including 6'h3F, lands on the early return path.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;

  // state slots, each one bit of the state vector
  localparam int NUM_ST     = 9;
  localparam int ST_FETCH   = 0;
  localparam int ST_DECODE  = 1;
  localparam int ST_MEMADDR = 2;
  localparam int ST_EXEC    = 3;
  localparam int ST_BRANCH  = 4;
  localparam int ST_MEMRD   = 5;
  localparam int ST_MEMWR   = 6;
  localparam int ST_RWB     = 7;
  localparam int ST_LDWB    = 8;

  localparam int ALU_OP_W = 3;
  typedef logic [ALU_OP_W-1:0] aluOp_t;

  localparam aluOp_t ALU_AND = 3'b000;
  localparam aluOp_t ALU_OR  = 3'b001;
  localparam aluOp_t ALU_ADD = 3'b010;
  localparam aluOp_t ALU_SUB = 3'b110;
  localparam aluOp_t ALU_SLT = 3'b111;

  localparam int BSEL_W = 2;
  localparam logic [BSEL_W-1:0] BSEL_REG  = 2'd0;
  localparam logic [BSEL_W-1:0] BSEL_FOUR = 2'd1;
  localparam logic [BSEL_W-1:0] BSEL_IMM  = 2'd2;
  localparam logic [BSEL_W-1:0] BSEL_IMM4 = 2'd3;

  typedef enum logic [2:0] {
    CL_RTYPE,
    CL_LOAD,
    CL_STORE,
    CL_BEQ,
    CL_OTHER
  } instrClass_e;

  typedef struct packed {
    logic              pcWrite;
    logic              pcFromAluOut;
    logic              irWrite;
    logic              memRead;
    logic              memWrite;
    logic              addrFromAluOut;
    logic              loadRegAB;
    logic              loadAluOut;
    logic              regWrite;
    logic              dstIsRd;
    logic              wbFromMdr;
    logic              aluAFromReg;
    logic [BSEL_W-1:0] aluBSel;
    aluOp_t            aluOp;
    logic              instrDone;
  } ctrlStrobes_t;

endpackage

// File: rtl/mcc_decode.sv
`timescale 1ns/1ps
module mcc_decode
  import mcc_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6,
  parameter logic [OPC_W-1:0] OPC_RTYPE = 'h00,
  parameter logic [OPC_W-1:0] OPC_LW    = 'h23,
  parameter logic [OPC_W-1:0] OPC_SW    = 'h2B,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 'h04
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output instrClass_e      cls,
  output aluOp_t           rOp
);

  localparam logic [FN_W-1:0] FN_ADD = FN_W'('h20);
  localparam logic [FN_W-1:0] FN_SUB = FN_W'('h22);
  localparam logic [FN_W-1:0] FN_AND = FN_W'('h24);
  localparam logic [FN_W-1:0] FN_OR  = FN_W'('h25);
  localparam logic [FN_W-1:0] FN_SLT = FN_W'('h2A);

  always_comb begin
    if (opcode == OPC_RTYPE)    cls = CL_RTYPE;
    else if (opcode == OPC_LW)  cls = CL_LOAD;
    else if (opcode == OPC_SW)  cls = CL_STORE;
    else if (opcode == OPC_BEQ) cls = CL_BEQ;
    else                        cls = CL_OTHER;
  end

  // unlisted function codes fall back to addition
  always_comb begin
    case (funct)
      FN_ADD:  rOp = ALU_ADD;
      FN_SUB:  rOp = ALU_SUB;
      FN_AND:  rOp = ALU_AND;
      FN_OR:   rOp = ALU_OR;
      FN_SLT:  rOp = ALU_SLT;
      default: rOp = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/mcc_seq.sv
`timescale 1ns/1ps
module mcc_seq
  import mcc_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  instrClass_e       cls,
  output logic [NUM_ST-1:0] stVec
);

  localparam int ST_W = $clog2(NUM_ST);

  logic [NUM_ST-1:0] nxtVec;

  // the class is stable after fetch, so later steps may branch on it again
  always_comb begin
    nxtVec = '0;
    if (stVec[ST_FETCH]) begin
      nxtVec[ST_DECODE] = 1'b1;
    end else if (stVec[ST_DECODE]) begin
      case (cls)
        CL_RTYPE:          nxtVec[ST_EXEC]    = 1'b1;
        CL_LOAD, CL_STORE: nxtVec[ST_MEMADDR] = 1'b1;
        CL_BEQ:            nxtVec[ST_BRANCH]  = 1'b1;
        default:           nxtVec[ST_FETCH]   = 1'b1;
      endcase
    end else if (stVec[ST_MEMADDR]) begin
      if (cls == CL_LOAD) nxtVec[ST_MEMRD] = 1'b1;
      else                nxtVec[ST_MEMWR] = 1'b1;
    end else if (stVec[ST_MEMRD]) begin
      nxtVec[ST_LDWB] = 1'b1;
    end else if (stVec[ST_EXEC]) begin
      nxtVec[ST_RWB] = 1'b1;
    end else begin
      // final steps, and any empty vector, go back to fetch
      nxtVec[ST_FETCH] = 1'b1;
    end
  end

  generate
    if (ONE_HOT) begin : g_oneHot
      logic [NUM_ST-1:0] stReg;
      always_ff @(posedge clk) begin
        if (rst) stReg <= NUM_ST'(1) << ST_FETCH;
        else     stReg <= nxtVec;
      end
      assign stVec = stReg;
    end else begin : g_binary
      logic [ST_W-1:0] stIdx;
      logic [ST_W-1:0] nxtIdx;
      always_comb begin
        nxtIdx = '0;
        for (int i = 0; i < NUM_ST; i++)
          if (nxtVec[i]) nxtIdx = ST_W'(i);
      end
      always_ff @(posedge clk) begin
        if (rst) stIdx <= ST_W'(ST_FETCH);
        else     stIdx <= nxtIdx;
      end
      always_comb begin
        for (int i = 0; i < NUM_ST; i++)
          stVec[i] = (stIdx == ST_W'(i));
      end
    end
  endgenerate

endmodule

// File: rtl/mcc_strobe.sv
`timescale 1ns/1ps
module mcc_strobe
  import mcc_pkg::*;
(
  input  logic [NUM_ST-1:0] stVec,
  input  instrClass_e       cls,
  input  aluOp_t            rOp,
  input  logic              aEqB,
  output ctrlStrobes_t      strb
);

  always_comb begin
    strb       = '0;
    strb.aluOp = ALU_ADD;

    if (stVec[ST_FETCH]) begin
      strb.memRead = 1'b1;
      strb.irWrite = 1'b1;
      strb.pcWrite = 1'b1;
      strb.aluBSel = BSEL_FOUR;
    end

    if (stVec[ST_DECODE]) begin
      strb.loadRegAB  = 1'b1;
      strb.loadAluOut = 1'b1;
      strb.aluBSel    = BSEL_IMM4;
      strb.instrDone  = (cls == CL_OTHER);
    end

    if (stVec[ST_MEMADDR]) begin
      strb.aluAFromReg = 1'b1;
      strb.aluBSel     = BSEL_IMM;
      strb.loadAluOut  = 1'b1;
    end

    if (stVec[ST_EXEC]) begin
      strb.aluAFromReg = 1'b1;
      strb.aluBSel     = BSEL_REG;
      strb.aluOp       = rOp;
      strb.loadAluOut  = 1'b1;
    end

    if (stVec[ST_BRANCH]) begin
      strb.aluAFromReg  = 1'b1;
      strb.aluBSel      = BSEL_REG;
      strb.aluOp        = ALU_SUB;
      strb.pcFromAluOut = 1'b1;
      strb.pcWrite      = aEqB;
      strb.instrDone    = 1'b1;
    end

    if (stVec[ST_MEMRD]) begin
      strb.memRead        = 1'b1;
      strb.addrFromAluOut = 1'b1;
    end

    if (stVec[ST_MEMWR]) begin
      strb.memWrite       = 1'b1;
      strb.addrFromAluOut = 1'b1;
      strb.instrDone      = 1'b1;
    end

    if (stVec[ST_RWB]) begin
      strb.regWrite  = 1'b1;
      strb.dstIsRd   = 1'b1;
      strb.instrDone = 1'b1;
    end

    if (stVec[ST_LDWB]) begin
      strb.regWrite  = 1'b1;
      strb.wbFromMdr = 1'b1;
      strb.instrDone = 1'b1;
    end
  end

endmodule

// File: rtl/mcc_ctrl.sv
`timescale 1ns/1ps
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6,
  parameter logic [OPC_W-1:0] OPC_RTYPE = 'h00,
  parameter logic [OPC_W-1:0] OPC_LW    = 'h23,
  parameter logic [OPC_W-1:0] OPC_SW    = 'h2B,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 'h04,
  parameter bit ONE_HOT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             aEqB,
  output logic             pcWrite,
  output logic             pcFromAluOut,
  output logic             irWrite,
  output logic             memRead,
  output logic             memWrite,
  output logic             addrFromAluOut,
  output logic             loadRegAB,
  output logic             loadAluOut,
  output logic             regWrite,
  output logic             dstIsRd,
  output logic             wbFromMdr,
  output logic             aluAFromReg,
  output logic [1:0]       aluBSel,
  output logic [2:0]       aluOp,
  output logic             instrDone
);

  instrClass_e       cls;
  aluOp_t            rOp;
  logic [NUM_ST-1:0] stVec;
  ctrlStrobes_t      strb;

  mcc_decode #(
    .OPC_W(OPC_W), .FN_W(FN_W),
    .OPC_RTYPE(OPC_RTYPE), .OPC_LW(OPC_LW), .OPC_SW(OPC_SW), .OPC_BEQ(OPC_BEQ)
  ) u_decode (
    .opcode(opcode), .funct(funct), .cls(cls), .rOp(rOp)
  );

  mcc_seq #(.ONE_HOT(ONE_HOT)) u_seq (
    .clk(clk), .rst(rst), .cls(cls), .stVec(stVec)
  );

  mcc_strobe u_strobe (
    .stVec(stVec), .cls(cls), .rOp(rOp), .aEqB(aEqB), .strb(strb)
  );

  assign pcWrite        = strb.pcWrite;
  assign pcFromAluOut   = strb.pcFromAluOut;
  assign irWrite        = strb.irWrite;
  assign memRead        = strb.memRead;
  assign memWrite       = strb.memWrite;
  assign addrFromAluOut = strb.addrFromAluOut;
  assign loadRegAB      = strb.loadRegAB;
  assign loadAluOut     = strb.loadAluOut;
  assign regWrite       = strb.regWrite;
  assign dstIsRd        = strb.dstIsRd;
  assign wbFromMdr      = strb.wbFromMdr;
  assign aluAFromReg    = strb.aluAFromReg;
  assign aluBSel        = strb.aluBSel;
  assign aluOp          = strb.aluOp;
  assign instrDone      = strb.instrDone;

endmodule

// File: rtl/mcc_ctrl_chk.sv
`timescale 1ns/1ps
module mcc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       aEqB,
  input logic       pcWrite,
  input logic       pcFromAluOut,
  input logic       irWrite,
  input logic       memRead,
  input logic       memWrite,
  input logic       addrFromAluOut,
  input logic       loadRegAB,
  input logic       loadAluOut,
  input logic       regWrite,
  input logic       dstIsRd,
  input logic       wbFromMdr,
  input logic       aluAFromReg,
  input logic [1:0] aluBSel,
  input logic       instrDone
);

  logic prevRst;
  always_ff @(posedge clk) prevRst <= rst;

  a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
    prevRst |-> (irWrite && pcWrite && memRead && !addrFromAluOut));

  a_r3_decode_follows_fetch: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (loadRegAB && loadAluOut && !irWrite && !pcWrite && !regWrite
                 && !memWrite && !memRead && aluBSel == 2'b11));

  a_r4_pc_target_only_if_equal: assert property (@(posedge clk) disable iff (rst)
    (pcWrite && pcFromAluOut) |-> (aEqB && instrDone));

  a_r5_exec_then_rd_write: assert property (@(posedge clk) disable iff (rst)
    (aluAFromReg && loadAluOut && aluBSel == 2'b00) |=> (regWrite && dstIsRd && !wbFromMdr));

  a_r6_read_then_rt_write: assert property (@(posedge clk) disable iff (rst)
    (memRead && addrFromAluOut) |=> (regWrite && wbFromMdr && !dstIsRd));

  a_r7_store_is_final: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> (addrFromAluOut && instrDone && !regWrite));

  a_r9_regwrite_final_only: assert property (@(posedge clk) disable iff (rst)
    regWrite |-> (instrDone && !pcWrite && !memWrite));

  a_r9_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memRead, memWrite}));

  a_r10_done_then_fetch: assert property (@(posedge clk) disable iff (rst)
    instrDone |=> irWrite);

endmodule

bind mcc_ctrl mcc_ctrl_chk u_chk (.*);

// File: tb/sim_mcc_ctrl.sv
`timescale 1ns/1ps
module sim_mcc_ctrl;
  import mcc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycCount = 0;
  bit finished = 1'b0;

  // behavioural datapath state
  logic [31:0] pc, irReg, aReg, bReg, aluOutReg, mdr, nextInstr;
  logic [31:0] mRegs [32];
  logic [31:0] mMem  [32];
  // reference architectural state
  logic [31:0] gPc;
  logic [31:0] gRegs [32];
  logic [31:0] gMem  [32];

  logic [5:0] opcode, funct;
  logic aEqB;
  assign opcode = irReg[31:26];
  assign funct  = irReg[5:0];
  assign aEqB   = (aReg == bReg);

  logic pcWrite, pcFromAluOut, irWrite, memRead, memWrite, addrFromAluOut;
  logic loadRegAB, loadAluOut, regWrite, dstIsRd, wbFromMdr, aluAFromReg, instrDone;
  logic [1:0] aluBSel;
  logic [2:0] aluOp;

  logic pcWrite1, pcFromAluOut1, irWrite1, memRead1, memWrite1, addrFromAluOut1;
  logic loadRegAB1, loadAluOut1, regWrite1, dstIsRd1, wbFromMdr1, aluAFromReg1, instrDone1;
  logic [1:0] aluBSel1;
  logic [2:0] aluOp1;

  mcc_ctrl #(.ONE_HOT(1'b1)) u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .aEqB(aEqB),
    .pcWrite(pcWrite), .pcFromAluOut(pcFromAluOut), .irWrite(irWrite),
    .memRead(memRead), .memWrite(memWrite), .addrFromAluOut(addrFromAluOut),
    .loadRegAB(loadRegAB), .loadAluOut(loadAluOut), .regWrite(regWrite),
    .dstIsRd(dstIsRd), .wbFromMdr(wbFromMdr), .aluAFromReg(aluAFromReg),
    .aluBSel(aluBSel), .aluOp(aluOp), .instrDone(instrDone)
  );

  mcc_ctrl #(.ONE_HOT(1'b0)) u1 (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .aEqB(aEqB),
    .pcWrite(pcWrite1), .pcFromAluOut(pcFromAluOut1), .irWrite(irWrite1),
    .memRead(memRead1), .memWrite(memWrite1), .addrFromAluOut(addrFromAluOut1),
    .loadRegAB(loadRegAB1), .loadAluOut(loadAluOut1), .regWrite(regWrite1),
    .dstIsRd(dstIsRd1), .wbFromMdr(wbFromMdr1), .aluAFromReg(aluAFromReg1),
    .aluBSel(aluBSel1), .aluOp(aluOp1), .instrDone(instrDone1)
  );

  logic [17:0] outs0, outs1;
  assign outs0 = {pcWrite, pcFromAluOut, irWrite, memRead, memWrite, addrFromAluOut,
                  loadRegAB, loadAluOut, regWrite, dstIsRd, wbFromMdr, aluAFromReg,
                  aluBSel, aluOp, instrDone};
  assign outs1 = {pcWrite1, pcFromAluOut1, irWrite1, memRead1, memWrite1, addrFromAluOut1,
                  loadRegAB1, loadAluOut1, regWrite1, dstIsRd1, wbFromMdr1, aluAFromReg1,
                  aluBSel1, aluOp1, instrDone1};

  function automatic logic [31:0] initReg(int i);
    return (i == 0) ? 32'd0 : ((32'(i) * 32'h9E3779B1) ^ 32'h0F0F1234);
  endfunction

  function automatic logic [31:0] initMem(int i);
    return (32'(i) * 32'h01000193) ^ 32'hA5A50000;
  endfunction

  function automatic logic [31:0] aluModel(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return a + b;
      3'b110:  return a - b;
      3'b111:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'hDEADBEEF;
    endcase
  endfunction

  // expected aluOp code for a function field (R5)
  function automatic logic [2:0] expFnOp(logic [5:0] fn);
    case (fn)
      6'h22:   return 3'b110;
      6'h24:   return 3'b000;
      6'h25:   return 3'b001;
      6'h2A:   return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  // datapath model driven by u0
  always @(posedge clk) begin : model
    logic [31:0] opA, opB, res, sx;
    logic [4:0] dst;
    if (rst) begin
      pc <= 32'd0; irReg <= 32'd0; aReg <= 32'd0; bReg <= 32'd1;
      aluOutReg <= 32'd0; mdr <= 32'd0;
      for (int i = 0; i < 32; i++) begin
        mRegs[i] <= initReg(i);
        mMem[i]  <= initMem(i);
      end
    end else begin
      sx  = {{16{irReg[15]}}, irReg[15:0]};
      opA = aluAFromReg ? aReg : pc;
      case (aluBSel)
        2'd0:    opB = bReg;
        2'd1:    opB = 32'd4;
        2'd2:    opB = sx;
        default: opB = sx << 2;
      endcase
      res = aluModel(aluOp, opA, opB);
      if (irWrite)   irReg <= nextInstr;
      if (pcWrite)   pc <= pcFromAluOut ? aluOutReg : res;
      if (loadRegAB) begin
        aReg <= mRegs[irReg[25:21]];
        bReg <= mRegs[irReg[20:16]];
      end
      if (loadAluOut) aluOutReg <= res;
      if (memRead && addrFromAluOut) mdr <= mMem[aluOutReg[6:2]];
      if (memWrite) mMem[aluOutReg[6:2]] <= bReg;
      if (regWrite) begin
        dst = dstIsRd ? irReg[15:11] : irReg[20:16];
        if (dst != 5'd0) mRegs[dst] <= wbFromMdr ? mdr : aluOutReg;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic goldReset();
    gPc = 32'd0;
    for (int i = 0; i < 32; i++) begin
      gRegs[i] = initReg(i);
      gMem[i]  = initMem(i);
    end
  endtask

  task automatic refExec(input logic [31:0] ins, output int cyc, output int pcW,
                         output int memW, output int regW, output string tag);
    logic [5:0] op; logic [4:0] rs, rt, rd; logic [31:0] sx, addr, r;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sx = {{16{ins[15]}}, ins[15:0]};
    gPc = gPc + 32'd4;
    pcW = 1; memW = 0; regW = 0;
    case (op)
      6'h00: begin
        case (ins[5:0])
          6'h22:   r = gRegs[rs] - gRegs[rt];
          6'h24:   r = gRegs[rs] & gRegs[rt];
          6'h25:   r = gRegs[rs] | gRegs[rt];
          6'h2A:   r = ($signed(gRegs[rs]) < $signed(gRegs[rt])) ? 32'd1 : 32'd0;
          default: r = gRegs[rs] + gRegs[rt];
        endcase
        if (rd != 5'd0) gRegs[rd] = r;
        cyc = 4; regW = 1; tag = "R5";
      end
      6'h23: begin
        addr = gRegs[rs] + sx;
        if (rt != 5'd0) gRegs[rt] = gMem[addr[6:2]];
        cyc = 5; regW = 1; tag = "R6";
      end
      6'h2B: begin
        addr = gRegs[rs] + sx;
        gMem[addr[6:2]] = gRegs[rt];
        cyc = 4; memW = 1; tag = "R7";
      end
      6'h04: begin
        if (gRegs[rs] == gRegs[rt]) begin
          gPc = gPc + (sx << 2);
          pcW = 2;
        end
        cyc = 3; tag = "R4";
      end
      default: begin
        cyc = 2; tag = "R8";
      end
    endcase
  endtask

  // entered at a negedge while in fetch; leaves at the negedge of the next fetch
  task automatic runInstr(input logic [31:0] ins);
    int expCyc, expPcW, expMemW, expRegW;
    int cyc, nPcW, nMemW, nRegW, lockBad;
    bit done, regsOk, memOk;
    string tag;
    nextInstr = ins;
    refExec(ins, expCyc, expPcW, expMemW, expRegW, tag);
    chk(irWrite && pcWrite && memRead && !addrFromAluOut && !pcFromAluOut &&
        !aluAFromReg && aluBSel == 2'd1 && aluOp == 3'b010,
        "R2 fetch controls", 32'(outs0), 32'h0);
    cyc = 0; done = 1'b0; nPcW = 0; nMemW = 0; nRegW = 0; lockBad = 0;
    while (!done && cyc < 8) begin
      cyc++;
      if (cyc == 2)
        chk({pcWrite, irWrite, memRead, memWrite, regWrite, loadRegAB, loadAluOut,
             aluAFromReg, aluBSel, aluOp} == 12'b00000_110_11_010,
            "R3 decode controls", 32'(outs0), 32'h0);
      if (cyc == 3 && ins[31:26] == 6'h00)
        chk(aluOp == expFnOp(ins[5:0]), "R5 aluOp", 32'(aluOp), 32'(expFnOp(ins[5:0])));
      if (outs0 !== outs1) lockBad++;
      nPcW  += int'(pcWrite);
      nMemW += int'(memWrite);
      nRegW += int'(regWrite);
      if (regWrite && !instrDone) nRegW += 100;
      done = instrDone;
      @(posedge clk);
      @(negedge clk);
    end
    chk(cyc == expCyc, {tag, " R10 cycle count"}, 32'(cyc), 32'(expCyc));
    chk(nPcW == expPcW && nMemW == expMemW && nRegW == expRegW, "R9 write counts",
        32'(nPcW * 256 + nMemW * 16 + nRegW), 32'(expPcW * 256 + expMemW * 16 + expRegW));
    chk(lockBad == 0, "R11 lockstep", 32'(lockBad), 32'd0);
    chk(pc == gPc, {tag, " pc"}, pc, gPc);
    regsOk = 1'b1; memOk = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (mRegs[i] !== gRegs[i]) regsOk = 1'b0;
      if (mMem[i]  !== gMem[i])  memOk  = 1'b0;
    end
    chk(regsOk, {tag, " registers"}, ins, 32'h0);
    chk(memOk,  {tag, " memory"},    ins, 32'h0);
  endtask

  function automatic logic [31:0] mkR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] mkI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] mkRand();
    int pick;
    logic [5:0] fnList [7];
    logic [5:0] op;
    logic [4:0] rs;
    fnList = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h27, 6'h00};
    pick = $urandom_range(0, 9);
    rs = 5'($urandom_range(0, 31));
    if (pick <= 2)
      return mkR(rs, 5'($urandom), 5'($urandom), fnList[$urandom_range(0, 6)]);
    if (pick <= 4) return mkI(6'h23, rs, 5'($urandom), 16'($urandom));
    if (pick <= 6) return mkI(6'h2B, rs, 5'($urandom), 16'($urandom));
    if (pick <= 8)
      return mkI(6'h04, rs, ($urandom_range(0, 1) == 1) ? rs : 5'($urandom), 16'($urandom));
    do op = 6'($urandom); while (op == 6'h00 || op == 6'h23 || op == 6'h2B || op == 6'h04);
    return mkI(op, rs, 5'($urandom), 16'($urandom));
  endfunction

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    nextInstr = 32'd0;
    goldReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: fetch controls right after reset
    chk(irWrite && pcWrite && memRead && !instrDone && pc == 32'd0, "R1 reset state", 32'(outs0), 32'h0);

    // directed corner cases
    runInstr(mkR(5'd3, 5'd4, 5'd5, 6'h20));         // add
    runInstr(mkR(5'd6, 5'd7, 5'd8, 6'h2A));         // slt, signed
    runInstr(mkR(5'd1, 5'd2, 5'd0, 6'h22));         // rd=0 left unchanged
    runInstr(mkR(5'd9, 5'd10, 5'd11, 6'h3D));       // unlisted function: add
    runInstr(mkI(6'h2B, 5'd0, 5'd12, 16'h0040));    // store
    runInstr(mkI(6'h23, 5'd0, 5'd13, 16'h0040));    // load same word back
    runInstr(mkI(6'h23, 5'd5, 5'd14, 16'hFFF8));    // negative offset
    runInstr(mkI(6'h23, 5'd2, 5'd0, 16'h0010));     // load to r0
    runInstr(mkI(6'h04, 5'd0, 5'd0, 16'hFFFC));     // taken, backwards
    runInstr(mkI(6'h04, 5'd7, 5'd7, 16'h0011));     // taken, forwards
    runInstr(mkI(6'h04, 5'd1, 5'd2, 16'h0020));     // not taken
    runInstr(mkI(6'h3F, 5'd1, 5'd2, 16'h1234));     // other opcode
    runInstr(mkI(6'h02, 5'd3, 5'd3, 16'h0001));     // other opcode

    // reset in the middle of a load (R1)
    nextInstr = mkI(6'h23, 5'd1, 5'd2, 16'h0008);
    repeat (2) begin @(posedge clk); @(negedge clk); end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    goldReset();
    chk(irWrite && pcWrite && memRead && !addrFromAluOut && !regWrite && pc == 32'd0,
        "R1 mid-instruction reset", 32'(outs0), 32'h0);

    for (int n = 0; n < 400; n++) runInstr(mkRand());

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule